// File: doc/BRIEF.md
# Interrupt Stack Frame Push Sequencer

This block delivers an interrupt or exception through an already fetched gate entry. On a start pulse it captures the gate and the interrupted context, then works out the frame. The frame depends on whether the processor is in protected mode and whether the handler runs at a more privileged ring. It also depends on whether the interrupted code ran in virtual-8086 mode and on the gate size. The block then issues the stack words one at a time over a request/acknowledge handshake, each with its value, its width and its stack address.

When the last word is acknowledged, the block pulses `done`. At that point its result outputs hold the new code selector, the new instruction pointer, the updated flags word, the new stack segment and pointer, and the new privilege level. A fault answer to any push abandons the frame and pulses `fault` instead. Descriptor validation, task gates and the memory accesses themselves are handled elsewhere.

Top module: `irq_frame_seq`

## Requirements
- R1: After reset, `pushReq`, `busy`, `done` and `fault` are all low.
- R2: The flags word, the old code selector and the old instruction pointer are always pushed, in that order. In protected mode with `errValid` high, `errCode` follows as the last word.
- R3: In protected mode a stack switch happens when `oldCpl` exceeds `gateSel[1:0]` (the target RPL) or when `oldFlags[17]` (VM) is set. On a switch the old SS and then the old ESP are pushed ahead of the flags. The pushes start from `ringSp[RPL]`, and `newSs` = `ringSs[RPL]` and `newCpl` = RPL. Without a switch the stack stays at `oldSs`/`oldEsp` and `newCpl` = `oldCpl`.
- R4: In protected mode with `oldFlags[17]` set, GS, FS, DS and ES are pushed in that order before anything else, and `nullDataSegs` goes high. Otherwise it is low.
- R5: `gateKind` bit 1 selects a 32-bit gate and bit 0 a trap gate. Under a 32-bit gate in protected mode, pushes have `pushWide`=1 and carry the full 32-bit value. Under any other gate, `pushWide`=0 and `pushData` carries the low 16 bits with the upper half zero.
- R6: Before each push, the stack pointer is lowered by 4 (wide) or 2 (narrow). `pushAddr` is the lowered value, and `newEsp` equals the address of the last push.
- R7: `newCs` is the target selector. A 32-bit gate sets `newEip` to `gateOff`. A 16-bit gate keeps `oldEip[31:16]` and takes the low half of the offset.
- R8: `newFlags` is `oldFlags` with these changes: bit 8 (TF) is always cleared; bit 9 (IF) is cleared for interrupt gates and kept for trap gates; bit 14 (NT) is cleared in protected mode; bit 17 (VM) is cleared when the stack switches.
- R9: With `protMode` low, `ivtEntry[15:0]` is the offset and `ivtEntry[31:16]` the selector. The frame is a narrow interrupt-gate frame with no stack switch. `gateKind`, `errValid` and VM are ignored, and NT is kept.
- R10: While a push is not answered, `pushReq` stays high with `pushData`, `pushWide` and `pushAddr` unchanged.
- R11: `pushFault` during a push ends the frame. `fault` pulses for one cycle, `done` does not pulse, and no further push is requested.
- R12: `done` pulses for one cycle after the last acknowledge. `busy` is high from the accepted start until `done` or `fault`, and a `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin delivery (accepted when idle) |
| protMode | input | 1 | Protected mode enable |
| gateKind | input | 2 | Bit 1: 32-bit gate, bit 0: trap gate |
| gateSel | input | 16 | Target code selector from the gate |
| gateOff | input | 32 | Handler offset from the gate (both halves) |
| ivtEntry | input | 32 | Real-mode far pointer (selector:offset) |
| oldCs | input | 16 | Interrupted code selector |
| oldEip | input | 32 | Interrupted instruction pointer |
| oldFlags | input | 32 | Interrupted flags word |
| oldSs | input | 16 | Interrupted stack selector |
| oldEsp | input | 32 | Interrupted stack pointer |
| oldCpl | input | 2 | Interrupted privilege level |
| dsSel | input | 16 | DS selector |
| esSel | input | 16 | ES selector |
| fsSel | input | 16 | FS selector |
| gsSel | input | 16 | GS selector |
| ringSs | input | 3x16 | Per-ring stack selectors, index = ring |
| ringSp | input | 3x32 | Per-ring stack pointers, index = ring |
| errValid | input | 1 | Error code requested |
| errCode | input | 32 | Error code value |
| pushAck | input | 1 | Current push completed |
| pushFault | input | 1 | Current push faulted |
| pushReq | output | 1 | Push request |
| pushData | output | 32 | Value to push |
| pushWide | output | 1 | 1: 32-bit push, 0: 16-bit push |
| pushAddr | output | 32 | Stack address of the push |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Frame completed (one cycle) |
| fault | output | 1 | Frame aborted (one cycle) |
| newCs | output | 16 | Loaded code selector |
| newEip | output | 32 | Loaded instruction pointer |
| newFlags | output | 32 | Updated flags word |
| newSs | output | 16 | Stack selector after delivery |
| newEsp | output | 32 | Stack pointer after delivery |
| newCpl | output | 2 | Privilege level after delivery |
| nullDataSegs | output | 1 | DS, ES, FS, GS are to be loaded null |

## Verification
The assertions assume that the gate and context inputs are steady only in the cycle `start` is accepted. They also assume that `pushAck` and `pushFault` mean something only while `pushReq` is high, and that a stack switch never targets ring 3. The bench keeps to these assumptions. It changes the context inputs only between frames and answers a push only on a cycle where it sees `pushReq`. Every switching scenario it builds uses a target RPL of 0 or 1.

// File: rtl/irq_frame_pkg.sv
package irq_frame_pkg;
  localparam int WORD_W     = 32;
  localparam int SEL_W      = 16;
  localparam int HALF_W     = WORD_W / 2;
  localparam int NUM_RINGS  = 3;
  localparam int SLOT_COUNT = 10;
  localparam int SLOT_W     = $clog2(SLOT_COUNT);

  localparam int FLAG_TF = 8;
  localparam int FLAG_IF = 9;
  localparam int FLAG_NT = 14;
  localparam int FLAG_VM = 17;

  // Frame word slots, numbered in push order.
  typedef enum logic [SLOT_W-1:0] {
    SLOT_GS    = 4'd0,
    SLOT_FS    = 4'd1,
    SLOT_DS    = 4'd2,
    SLOT_ES    = 4'd3,
    SLOT_OLDSS = 4'd4,
    SLOT_OLDSP = 4'd5,
    SLOT_FLAGS = 4'd6,
    SLOT_CS    = 4'd7,
    SLOT_IP    = 4'd8,
    SLOT_ERR   = 4'd9
  } slot_e;

  typedef struct packed {
    logic capture;
    logic advance;
  } dp_strobe_t;
endpackage

// File: rtl/irq_frame_dp.sv
module irq_frame_dp
  import irq_frame_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  dp_strobe_t                       strobe,
  input  slot_e                            slot,
  input  logic                             protMode,
  input  logic [1:0]                       gateKind,
  input  logic [SEL_W-1:0]                 gateSel,
  input  logic [WORD_W-1:0]                gateOff,
  input  logic [WORD_W-1:0]                ivtEntry,
  input  logic [SEL_W-1:0]                 oldCs,
  input  logic [WORD_W-1:0]                oldEip,
  input  logic [WORD_W-1:0]                oldFlags,
  input  logic [SEL_W-1:0]                 oldSs,
  input  logic [WORD_W-1:0]                oldEsp,
  input  logic [1:0]                       oldCpl,
  input  logic [SEL_W-1:0]                 dsSel,
  input  logic [SEL_W-1:0]                 esSel,
  input  logic [SEL_W-1:0]                 fsSel,
  input  logic [SEL_W-1:0]                 gsSel,
  input  logic [NUM_RINGS-1:0][SEL_W-1:0]  ringSs,
  input  logic [NUM_RINGS-1:0][WORD_W-1:0] ringSp,
  input  logic                             errValid,
  input  logic [WORD_W-1:0]                errCode,
  output logic [SLOT_COUNT-1:0]            slotMask,
  output logic [WORD_W-1:0]                pushData,
  output logic                             pushWide,
  output logic [WORD_W-1:0]                pushAddr,
  output logic [SEL_W-1:0]                 newCs,
  output logic [WORD_W-1:0]                newEip,
  output logic [WORD_W-1:0]                newFlags,
  output logic [SEL_W-1:0]                 newSs,
  output logic [WORD_W-1:0]                newEsp,
  output logic [1:0]                       newCpl,
  output logic                             nullDataSegs
);
  localparam logic [1:0]        TOP_RING    = 2'(NUM_RINGS - 1);
  localparam logic [WORD_W-1:0] STEP_WIDE   = WORD_W'(4);
  localparam logic [WORD_W-1:0] STEP_NARROW = WORD_W'(2);
  localparam int                PAD_W       = WORD_W - SEL_W;

  // Decode of the raw inputs, used only in the capture cycle.
  logic [1:0]        tgtRpl, ringIdx;
  logic              inVm, doSwitch, wideGate, trapGate;
  logic [SEL_W-1:0]  tgtSel;
  logic [WORD_W-1:0] tgtEip, ringSpPick, flagsNext;
  logic [SEL_W-1:0]  ringSsPick;
  logic [SLOT_COUNT-1:0] maskNext;

  always_comb begin
    tgtRpl   = gateSel[1:0];
    inVm     = protMode & oldFlags[FLAG_VM];
    doSwitch = protMode & ((oldCpl > tgtRpl) | oldFlags[FLAG_VM]);
    wideGate = protMode & gateKind[1];
    trapGate = protMode & gateKind[0];
    ringIdx  = (tgtRpl > TOP_RING) ? TOP_RING : tgtRpl;

    if (protMode) begin
      tgtSel = gateSel;
      tgtEip = wideGate ? gateOff : {oldEip[WORD_W-1:HALF_W], gateOff[HALF_W-1:0]};
    end else begin
      tgtSel = ivtEntry[WORD_W-1:HALF_W];
      tgtEip = {oldEip[WORD_W-1:HALF_W], ivtEntry[HALF_W-1:0]};
    end

    flagsNext          = oldFlags;
    flagsNext[FLAG_TF] = 1'b0;
    if (!trapGate) flagsNext[FLAG_IF] = 1'b0;
    if (protMode)  flagsNext[FLAG_NT] = 1'b0;
    if (doSwitch)  flagsNext[FLAG_VM] = 1'b0;

    maskNext             = '0;
    maskNext[SLOT_GS]    = inVm;
    maskNext[SLOT_FS]    = inVm;
    maskNext[SLOT_DS]    = inVm;
    maskNext[SLOT_ES]    = inVm;
    maskNext[SLOT_OLDSS] = doSwitch;
    maskNext[SLOT_OLDSP] = doSwitch;
    maskNext[SLOT_FLAGS] = 1'b1;
    maskNext[SLOT_CS]    = 1'b1;
    maskNext[SLOT_IP]    = 1'b1;
    maskNext[SLOT_ERR]   = protMode & errValid;
  end

  // Per-ring stack table lookup.
  always_comb begin
    ringSsPick = ringSs[0];
    ringSpPick = ringSp[0];
    for (int r = 1; r < NUM_RINGS; r++) begin
      if (ringIdx == 2'(r)) begin
        ringSsPick = ringSs[r];
        ringSpPick = ringSp[r];
      end
    end
  end

  // Captured frame contents.
  logic [SEL_W-1:0]  capGs, capFs, capDs, capEs, capSs, capCs;
  logic [WORD_W-1:0] capSp, capFlags, capEip, capErr;
  logic [WORD_W-1:0] stackPtr;
  logic              capWide;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capGs        <= '0;
      capFs        <= '0;
      capDs        <= '0;
      capEs        <= '0;
      capSs        <= '0;
      capCs        <= '0;
      capSp        <= '0;
      capFlags     <= '0;
      capEip       <= '0;
      capErr       <= '0;
      capWide      <= 1'b0;
      slotMask     <= '0;
      stackPtr     <= '0;
      newCs        <= '0;
      newEip       <= '0;
      newFlags     <= '0;
      newSs        <= '0;
      newCpl       <= '0;
      nullDataSegs <= 1'b0;
    end else if (strobe.capture) begin
      capGs        <= gsSel;
      capFs        <= fsSel;
      capDs        <= dsSel;
      capEs        <= esSel;
      capSs        <= oldSs;
      capCs        <= oldCs;
      capSp        <= oldEsp;
      capFlags     <= oldFlags;
      capEip       <= oldEip;
      capErr       <= errCode;
      capWide      <= wideGate;
      slotMask     <= maskNext;
      stackPtr     <= doSwitch ? ringSpPick : oldEsp;
      newCs        <= tgtSel;
      newEip       <= tgtEip;
      newFlags     <= flagsNext;
      newSs        <= doSwitch ? ringSsPick : oldSs;
      newCpl       <= doSwitch ? tgtRpl : oldCpl;
      nullDataSegs <= inVm;
    end else if (strobe.advance) begin
      stackPtr <= pushAddr;
    end
  end

  // Word selection and narrowing.
  logic [WORD_W-1:0] rawWord;

  always_comb begin
    case (slot)
      SLOT_GS:    rawWord = {{PAD_W{1'b0}}, capGs};
      SLOT_FS:    rawWord = {{PAD_W{1'b0}}, capFs};
      SLOT_DS:    rawWord = {{PAD_W{1'b0}}, capDs};
      SLOT_ES:    rawWord = {{PAD_W{1'b0}}, capEs};
      SLOT_OLDSS: rawWord = {{PAD_W{1'b0}}, capSs};
      SLOT_OLDSP: rawWord = capSp;
      SLOT_FLAGS: rawWord = capFlags;
      SLOT_CS:    rawWord = {{PAD_W{1'b0}}, capCs};
      SLOT_IP:    rawWord = capEip;
      default:    rawWord = capErr;
    endcase
    pushData = capWide ? rawWord : {{HALF_W{1'b0}}, rawWord[HALF_W-1:0]};
    pushWide = capWide;
    pushAddr = stackPtr - (capWide ? STEP_WIDE : STEP_NARROW);
  end

  assign newEsp = stackPtr;

  // Each accepted push lowers the stack by exactly one word of the gate size.
  assert_stack_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> ($past(newEsp) - newEsp == (capWide ? STEP_WIDE : STEP_NARROW)));

  // Real-mode delivery is narrow and keeps the privilege level.
  assert_real_narrow_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !protMode) |=> (!pushWide && newCpl == $past(oldCpl)));

  // Trace flag always cleared; interrupt flag survives only through a trap gate.
  assert_flag_rules_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (!newFlags[FLAG_TF] &&
      newFlags[FLAG_IF] == $past(oldFlags[FLAG_IF] && protMode && gateKind[0])));

  // Virtual-8086 entry always comes with a stack switch and a cleared VM flag.
  assert_vm_switch_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && protMode && oldFlags[FLAG_VM]) |=>
      (nullDataSegs && slotMask[SLOT_OLDSS] && !newFlags[FLAG_VM]));
endmodule

// File: rtl/irq_frame_ctrl.sv
module irq_frame_ctrl
  import irq_frame_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [SLOT_COUNT-1:0] slotMask,
  input  logic                  pushAck,
  input  logic                  pushFault,
  output dp_strobe_t            strobe,
  output slot_e                 slot,
  output logic                  pushReq,
  output logic                  busy,
  output logic                  done,
  output logic                  fault
);
  typedef enum logic [2:0] {ST_IDLE, ST_PICK, ST_PUSH, ST_FIN, ST_ABORT} state_e;

  state_e            state;
  logic [SLOT_W-1:0] curSlot, firstIdx, nextIdx;
  logic              nextFound;

  // Lowest enabled slot overall, and lowest enabled slot above the current one.
  always_comb begin
    firstIdx  = '0;
    nextIdx   = '0;
    nextFound = 1'b0;
    for (int i = SLOT_COUNT - 1; i >= 0; i--) begin
      if (slotMask[i]) firstIdx = SLOT_W'(i);
      if (slotMask[i] && (SLOT_W'(i) > curSlot)) begin
        nextIdx   = SLOT_W'(i);
        nextFound = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      curSlot <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) state <= ST_PICK;
        ST_PICK: begin
          curSlot <= firstIdx;
          state   <= ST_PUSH;
        end
        ST_PUSH: begin
          if (pushFault) begin
            state <= ST_ABORT;
          end else if (pushAck) begin
            if (nextFound) curSlot <= nextIdx;
            else           state   <= ST_FIN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    pushReq        = (state == ST_PUSH);
    done           = (state == ST_FIN);
    fault          = (state == ST_ABORT);
    busy           = (state != ST_IDLE);
    slot           = slot_e'(curSlot);
    strobe.capture = (state == ST_IDLE) && start;
    strobe.advance = (state == ST_PUSH) && pushAck && !pushFault;
  end

  // Faulted push: abort pulse next, no further request.
  assert_abort_R11: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && pushFault) |=> (fault && !pushReq && !done));

  // Accepted push with more to go: next word comes later in the frame order.
  assert_order_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && pushAck && !pushFault && nextFound) |=> (pushReq && curSlot > $past(curSlot)));

  // Unanswered push holds its slot.
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && !pushAck && !pushFault) |=> (pushReq && $stable(curSlot)));

  // Last acknowledged word: completion pulse, then idle.
  assert_finish_R12: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && pushAck && !pushFault && !nextFound) |=> (done ##1 !busy));
endmodule

// File: rtl/irq_frame_seq.sv
module irq_frame_seq
  import irq_frame_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             start,
  input  logic                             protMode,
  input  logic [1:0]                       gateKind,
  input  logic [SEL_W-1:0]                 gateSel,
  input  logic [WORD_W-1:0]                gateOff,
  input  logic [WORD_W-1:0]                ivtEntry,
  input  logic [SEL_W-1:0]                 oldCs,
  input  logic [WORD_W-1:0]                oldEip,
  input  logic [WORD_W-1:0]                oldFlags,
  input  logic [SEL_W-1:0]                 oldSs,
  input  logic [WORD_W-1:0]                oldEsp,
  input  logic [1:0]                       oldCpl,
  input  logic [SEL_W-1:0]                 dsSel,
  input  logic [SEL_W-1:0]                 esSel,
  input  logic [SEL_W-1:0]                 fsSel,
  input  logic [SEL_W-1:0]                 gsSel,
  input  logic [NUM_RINGS-1:0][SEL_W-1:0]  ringSs,
  input  logic [NUM_RINGS-1:0][WORD_W-1:0] ringSp,
  input  logic                             errValid,
  input  logic [WORD_W-1:0]                errCode,
  input  logic                             pushAck,
  input  logic                             pushFault,
  output logic                             pushReq,
  output logic [WORD_W-1:0]                pushData,
  output logic                             pushWide,
  output logic [WORD_W-1:0]                pushAddr,
  output logic                             busy,
  output logic                             done,
  output logic                             fault,
  output logic [SEL_W-1:0]                 newCs,
  output logic [WORD_W-1:0]                newEip,
  output logic [WORD_W-1:0]                newFlags,
  output logic [SEL_W-1:0]                 newSs,
  output logic [WORD_W-1:0]                newEsp,
  output logic [1:0]                       newCpl,
  output logic                             nullDataSegs
);
  dp_strobe_t            strobe;
  slot_e                 slot;
  logic [SLOT_COUNT-1:0] slotMask;

  irq_frame_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .slotMask(slotMask),
    .pushAck(pushAck), .pushFault(pushFault), .strobe(strobe), .slot(slot),
    .pushReq(pushReq), .busy(busy), .done(done), .fault(fault)
  );

  irq_frame_dp i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slot(slot),
    .protMode(protMode), .gateKind(gateKind), .gateSel(gateSel), .gateOff(gateOff),
    .ivtEntry(ivtEntry), .oldCs(oldCs), .oldEip(oldEip), .oldFlags(oldFlags),
    .oldSs(oldSs), .oldEsp(oldEsp), .oldCpl(oldCpl), .dsSel(dsSel), .esSel(esSel),
    .fsSel(fsSel), .gsSel(gsSel), .ringSs(ringSs), .ringSp(ringSp),
    .errValid(errValid), .errCode(errCode), .slotMask(slotMask),
    .pushData(pushData), .pushWide(pushWide), .pushAddr(pushAddr),
    .newCs(newCs), .newEip(newEip), .newFlags(newFlags), .newSs(newSs),
    .newEsp(newEsp), .newCpl(newCpl), .nullDataSegs(nullDataSegs)
  );
endmodule

// File: tb/test_irq_frame_seq.sv
module test_irq_frame_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic protMode;
  logic [1:0] gateKind, oldCpl;
  logic [15:0] gateSel, oldCs, oldSs, dsSel, esSel, fsSel, gsSel;
  logic [31:0] gateOff, ivtEntry, oldEip, oldFlags, oldEsp, errCode;
  logic [2:0][15:0] ringSs;
  logic [2:0][31:0] ringSp;
  logic errValid, pushAck = 1'b0, pushFault = 1'b0;
  logic pushReq, pushWide, busy, done, fault, nullDataSegs;
  logic [31:0] pushData, pushAddr, newEip, newFlags, newEsp;
  logic [15:0] newCs, newSs;
  logic [1:0] newCpl;

  irq_frame_seq i_irq_frame_seq (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0;

  logic [31:0] expData [16];
  logic [31:0] expAddr [16];
  logic        expWide;
  int          expN;
  logic [31:0] expFlags, expEip, expEsp;
  logic [15:0] expCs, expSs;
  logic [1:0]  expCpl;
  logic        expNull;

  logic [31:0] gotData [16];
  logic [31:0] gotAddr [16];
  logic        gotWide [16];
  int          gotN;
  bit          sawDone, sawFault;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic setBase();
    protMode = 1'b1; gateKind = 2'b10; gateSel = 16'h0008; gateOff = 32'hCAFE_BABE;
    ivtEntry = 32'hF000_E987; oldCs = 16'h1234; oldEip = 32'h8765_4321;
    oldFlags = 32'h0000_4302; oldSs = 16'h0023; oldEsp = 32'h0001_0000; oldCpl = 2'd0;
    gsSel = 16'h0A0A; fsSel = 16'h0B0B; dsSel = 16'h0C0C; esSel = 16'h0D0D;
    ringSs = {16'h0030, 16'h0020, 16'h0010};
    ringSp = {32'h0000_3000, 32'h0000_2000, 32'h0000_1000};
    errValid = 1'b0; errCode = 32'h0000_0ABC;
  endtask

  // Expected frame, derived from the requirements.
  task automatic addExp(input logic [31:0] v, inout logic [31:0] sp);
    sp = sp - (expWide ? 32'd4 : 32'd2);
    expData[expN] = expWide ? v : {16'h0, v[15:0]};
    expAddr[expN] = sp;
    expN++;
  endtask

  task automatic buildExp();
    logic sw, vm;
    logic [1:0] rpl;
    logic [31:0] sp;
    expN = 0;
    rpl = gateSel[1:0];
    vm = protMode && oldFlags[17];
    sw = protMode && ((oldCpl > rpl) || oldFlags[17]);
    expWide = protMode && gateKind[1];
    sp = sw ? ringSp[rpl] : oldEsp;
    if (vm) begin
      addExp({16'h0, gsSel}, sp); addExp({16'h0, fsSel}, sp);
      addExp({16'h0, dsSel}, sp); addExp({16'h0, esSel}, sp);
    end
    if (sw) begin
      addExp({16'h0, oldSs}, sp); addExp(oldEsp, sp);
    end
    addExp(oldFlags, sp); addExp({16'h0, oldCs}, sp); addExp(oldEip, sp);
    if (protMode && errValid) addExp(errCode, sp);
    expEsp = sp;
    expCs = protMode ? gateSel : ivtEntry[31:16];
    if (expWide) expEip = gateOff;
    else expEip = {oldEip[31:16], protMode ? gateOff[15:0] : ivtEntry[15:0]};
    expFlags = oldFlags;
    expFlags[8] = 1'b0;
    if (!(protMode && gateKind[0])) expFlags[9] = 1'b0;
    if (protMode) expFlags[14] = 1'b0;
    if (sw) expFlags[17] = 1'b0;
    expSs = sw ? ringSs[rpl] : oldSs;
    expCpl = sw ? rpl : oldCpl;
    expNull = vm;
  endtask

  // Start a frame and act as the stack port until it ends.
  task automatic runFrame(input int stall, input int faultAt, input bit injectStart);
    int waitLeft;
    bit inPush;
    logic [31:0] heldData, heldAddr;
    gotN = 0; sawDone = 0; sawFault = 0; waitLeft = stall; inPush = 0;
    heldData = '0; heldAddr = '0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int cyc = 0; cyc < 400; cyc++) begin
      @(negedge clk);
      pushAck = 1'b0; pushFault = 1'b0; start = 1'b0;
      if (done) begin sawDone = 1; break; end
      if (fault) begin sawFault = 1; break; end
      if (injectStart && gotN == 1) start = 1'b1;
      if (pushReq) begin
        if (!inPush) begin
          inPush = 1; heldData = pushData; heldAddr = pushAddr;
        end
        if (waitLeft > 0) begin
          waitLeft--;
        end else begin
          check(pushData == heldData && pushAddr == heldAddr, "R10", "held push data",
                pushData, heldData);
          gotData[gotN] = pushData; gotAddr[gotN] = pushAddr; gotWide[gotN] = pushWide;
          if (gotN == faultAt) pushFault = 1'b1;
          else pushAck = 1'b1;
          gotN++;
          inPush = 0; waitLeft = stall;
        end
      end
    end
  endtask

  task automatic verifyFrame(input string tag);
    check(sawDone, "R12", {tag, " done seen"}, 32'(sawDone), 32'd1);
    check(gotN == expN, "R2", {tag, " push count"}, 32'(gotN), 32'(expN));
    for (int k = 0; k < expN && k < gotN; k++) begin
      check(gotData[k] == expData[k], "R2", $sformatf("%s word %0d", tag, k), gotData[k], expData[k]);
      check(gotWide[k] == expWide, "R5", $sformatf("%s width %0d", tag, k), 32'(gotWide[k]), 32'(expWide));
      check(gotAddr[k] == expAddr[k], "R6", $sformatf("%s addr %0d", tag, k), gotAddr[k], expAddr[k]);
    end
    check(newEsp == expEsp, "R6", {tag, " final esp"}, newEsp, expEsp);
    check(newCs == expCs, "R7", {tag, " cs"}, 32'(newCs), 32'(expCs));
    check(newEip == expEip, "R7", {tag, " eip"}, newEip, expEip);
    check(newFlags == expFlags, "R8", {tag, " flags"}, newFlags, expFlags);
    check(newSs == expSs, "R3", {tag, " ss"}, 32'(newSs), 32'(expSs));
    check(newCpl == expCpl, "R3", {tag, " cpl"}, 32'(newCpl), 32'(expCpl));
    check(nullDataSegs == expNull, "R4", {tag, " null segs"}, 32'(nullDataSegs), 32'(expNull));
    @(negedge clk);
    check(!done && !busy, "R12", {tag, " done one cycle"}, {30'h0, done, busy}, 32'd0);
  endtask

  task automatic testReset();
    check(!pushReq && !busy && !done && !fault, "R1", "reset outputs",
          {28'h0, pushReq, busy, done, fault}, 32'd0);
  endtask

  task automatic testSameRing32();
    setBase();
    buildExp(); runFrame(0, -1, 0); verifyFrame("same ring 32-bit int gate");
  endtask

  task automatic testTrap16Err();
    setBase(); gateKind = 2'b01; errValid = 1'b1;
    buildExp(); runFrame(1, -1, 0); verifyFrame("16-bit trap gate with error");
    check(newFlags[9] == 1'b1, "R8", "trap keeps IF", 32'(newFlags[9]), 32'd1);
  endtask

  task automatic testRingSwitch();
    setBase(); oldCpl = 2'd3; gateSel = 16'h0049; gateKind = 2'b10; errValid = 1'b1;
    buildExp(); runFrame(2, -1, 0); verifyFrame("ring switch");
    check(gotData[0] == 32'h0000_0023, "R3", "old SS pushed first", gotData[0], 32'h23);
  endtask

  task automatic testVm86();
    setBase(); oldFlags = 32'h0002_4302; oldCpl = 2'd3; gateSel = 16'h0010; gateKind = 2'b11;
    buildExp(); runFrame(0, -1, 0); verifyFrame("vm86 entry");
    check(gotData[0] == 32'h0000_0A0A && gotData[3] == 32'h0000_0D0D, "R4", "GS first ES fourth",
          gotData[0], 32'h0A0A);
  endtask

  task automatic testReal();
    setBase(); protMode = 1'b0; gateKind = 2'b11; errValid = 1'b1; oldFlags = 32'h0002_4302;
    buildExp(); runFrame(1, -1, 0); verifyFrame("real mode");
    check(gotN == 3 && newFlags[14] == 1'b1, "R9", "real mode 3 words, NT kept",
          32'(gotN), 32'd3);
  endtask

  task automatic testFault();
    setBase(); oldCpl = 2'd2; gateSel = 16'h0009;
    buildExp(); runFrame(0, 2, 0);
    check(sawFault && !sawDone, "R11", "fault ends frame", {30'h0, sawFault, sawDone}, 32'd2);
    check(gotN == 3, "R11", "pushes up to fault", 32'(gotN), 32'd3);
    @(negedge clk);
    check(!pushReq && !fault && !busy, "R11", "no push after fault",
          {29'h0, pushReq, fault, busy}, 32'd0);
  endtask

  task automatic testBusyStart();
    setBase(); gateKind = 2'b00;
    buildExp(); runFrame(1, -1, 1); verifyFrame("start while busy");
    repeat (3) @(negedge clk);
    check(!pushReq && !busy, "R12", "start while busy ignored", {30'h0, pushReq, busy}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    setBase();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSameRing32();
    testTrap16Err();
    testRingSwitch();
    testVm86();
    testReal();
    testFault();
    testBusyStart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule